// File: doc/BRIEF.md
# Shader Control-Flow Sequencer

This block steps through a shader program's control-flow stream. It takes one 48-bit control-flow word per handshake and decides what happens next. It can launch an execution clause of up to six slots, and it resolves jumps, calls and returns against a four-entry return-address stack. Loop instructions go to an external loop unit, and the block waits for that unit's verdict before it moves on. A clause can be unconditional, gated by one bit of a 256-bit boolean constant bank, or gated by a predicate reduced across 64 lanes. Each clause-launching opcode has a variant that terminates the program.

The upstream fetch logic presents the word addressed by `next_pc` and holds it until `instr_ready` is high. The downstream clause engine consumes the clause descriptor while `clause_valid` is high. When a clause may rewrite the lane predicates (its predicate-clean bit is 0), the sequencer records that the predicate is stale. It then refuses the next predicate-gated instruction until `pred_valid` reports that fresh predicates are on `lane_pred`.

Top module: `cfs_sequencer`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `next_pc` is 0 and `clause_valid`, `prog_done`, `stack_err` and `loop_req` are 0. `instr_ready` is 1 whenever no predicate stall applies.
- R2: The opcode is in bits 47:44. An accepted clause opcode that runs drives `clause_valid` high for one cycle, starting on the edge after acceptance. At that point `clause_addr` equals bits 11:0 and `clause_len` equals bits 14:12. Every clause opcode, whether or not it runs, advances `next_pc` by one. Clause opcodes are 1, 2 (always run), 3, 4, 13, 14 (boolean gated) and 5, 6 (predicate gated).
- R3: For slot i (0..5), `slot_fetch[i]` equals word bit 16+2i (0 = ALU, 1 = fetch) and `slot_serial[i]` equals bit 17+2i.
- R4: Boolean-gated opcodes 3, 4, 13 and 14 run when `bool_bank[bits 41:34]` equals the expected value in bit 42.
- R5: A predicate-gated opcode (5, 6) with bit 42 = 1 runs when at least one lane has both `lane_live` and `lane_pred` set.
- R6: A predicate-gated opcode with bit 42 = 0 runs when at least one live lane has `lane_pred` = 0, that is, when the AND of live predicates is false. With no live lanes it does not run.
- R7: Opcode 2 always ends the program. Opcodes 4, 6 and 14 end it only when their clause runs; otherwise the sequencer continues with `next_pc` + 1. Once `prog_done` is set it stays set, `instr_ready` stays 0 and `next_pc` stays fixed.
- R8: A clause that runs with predicate-clean 0 marks the predicate stale. For opcodes 1, 2, 5 and 6, predicate-clean is bit 41. It is 0 for opcodes 3 and 4 and 1 for opcodes 13 and 14. While the predicate is stale and `pred_valid` is 0, `instr_ready` is 0 for opcodes 5 and 6. Clean clauses never cause this stall.
- R9: Opcode 11 jumps to bits 11:0 when bit 33 (forced) is set or when the boolean test of R4 passes. Otherwise it advances by one.
- R10: Opcode 9 under the same taken rule as R9 pushes `next_pc` + 1 and jumps to bits 11:0. Opcode 10 pops the stack into `next_pc`.
- R11: A taken call with four entries stacked, or a return with none, sets the sticky `stack_err`, leaves the stack unchanged and advances `next_pc` by one.
- R12: Opcodes 7 and 8 raise `loop_req` for one cycle, on the edge after acceptance, with the word on `loop_word`. They hold `instr_ready` low until `loop_ack`. On the edge that samples `loop_ack`, `next_pc` becomes `loop_target` if `loop_taken` is set, else `next_pc` + 1. Opcodes 0, 12 and 15 only advance `next_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Control-flow word present |
| instr_word | input | 48 | Control-flow word |
| instr_ready | output | 1 | Word accepted on this edge if valid |
| bool_bank | input | 256 | Boolean constant bank |
| lane_pred | input | 64 | Per-lane predicate |
| lane_live | input | 64 | Per-lane active and not killed |
| pred_valid | input | 1 | Lane predicates are up to date |
| clause_valid | output | 1 | Clause descriptor valid |
| clause_addr | output | 12 | Clause start address |
| clause_len | output | 3 | Clause instruction count |
| slot_fetch | output | 6 | Per-slot fetch (1) or ALU (0) |
| slot_serial | output | 6 | Per-slot serialize request |
| next_pc | output | 12 | Address of next control-flow word |
| prog_done | output | 1 | Program ended |
| stack_err | output | 1 | Sticky call-stack error |
| loop_req | output | 1 | Loop handoff strobe |
| loop_word | output | 48 | Loop instruction handed off |
| loop_ack | input | 1 | Loop unit response |
| loop_taken | input | 1 | Loop unit redirects |
| loop_target | input | 12 | Loop redirect address |

## Verification
`instr_ready` is combinational, so the bench samples it 1 ns after it drives a word. The clause descriptor, `next_pc`, `prog_done` and `stack_err` are all registered and change on the first rising edge after acceptance. A scoreboard monitor therefore compares them at the falling edge that follows that edge. `loop_req` rises on that same edge and is checked to have dropped one cycle later. The `next_pc` redirect lands on the edge that samples `loop_ack` and is checked at the next falling edge. The bench drives the predicate stall before any edge can accept the word, and then releases it with `pred_valid`.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

    localparam int WORD_W    = 48;
    localparam int ADDR_W    = 12;
    localparam int LEN_W     = 3;
    localparam int SLOTS     = 6;
    localparam int BIDX_W    = 8;

    localparam int LEN_LSB   = 12;
    localparam int SEQ_LSB   = 16;
    localparam int FORCE_BIT = 33;
    localparam int BIDX_LSB  = 34;
    localparam int CLEAN_BIT = 41;
    localparam int COND_BIT  = 42;
    localparam int OP_LSB    = 44;

    typedef enum logic [3:0] {
        OP_NOP          = 4'd0,
        OP_EXEC         = 4'd1,
        OP_EXEC_END     = 4'd2,
        OP_BEXEC        = 4'd3,
        OP_BEXEC_END    = 4'd4,
        OP_PEXEC        = 4'd5,
        OP_PEXEC_END    = 4'd6,
        OP_LOOP_BEGIN   = 4'd7,
        OP_LOOP_CLOSE   = 4'd8,
        OP_CALL         = 4'd9,
        OP_RET          = 4'd10,
        OP_JUMP         = 4'd11,
        OP_ALLOC        = 4'd12,
        OP_BEXEC_CL     = 4'd13,
        OP_BEXEC_CL_END = 4'd14,
        OP_VFETCH_DONE  = 4'd15
    } cf_op_e;

    typedef enum logic [2:0] {
        K_CLAUSE_ALWAYS,
        K_CLAUSE_BOOL,
        K_CLAUSE_PRED,
        K_JUMP,
        K_CALL,
        K_RET,
        K_LOOP,
        K_PASS
    } cf_kind_e;

    typedef enum logic [1:0] {
        S_RUN,
        S_LOOP,
        S_DONE
    } seq_state_e;

    typedef struct packed {
        cf_kind_e                kind;
        logic                    is_end;
        logic                    clean;
        logic                    cond;
        logic                    force_take;
        logic [BIDX_W-1:0]       bidx;
        logic [ADDR_W-1:0]       target;
        logic [LEN_W-1:0]        len;
        logic [SLOTS-1:0]        fetch;
        logic [SLOTS-1:0]        serial;
    } cf_dec_t;

    function automatic logic is_clause(cf_kind_e k);
        return (k == K_CLAUSE_ALWAYS) || (k == K_CLAUSE_BOOL) || (k == K_CLAUSE_PRED);
    endfunction

endpackage

// File: rtl/cfs_decode.sv
module cfs_decode
    import cfs_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output cf_dec_t           dec_o
);
    cf_op_e           op;
    logic [SLOTS-1:0] fetch_v;
    logic [SLOTS-1:0] serial_v;
    logic             unused_w;

    assign op       = cf_op_e'(word_i[OP_LSB +: 4]);
    assign unused_w = ^{word_i[43], word_i[32:28], word_i[15]};

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign fetch_v[g]  = word_i[SEQ_LSB + 2*g];
        assign serial_v[g] = word_i[SEQ_LSB + 2*g + 1];
    end

    always_comb begin
        dec_o            = '0;
        dec_o.kind       = K_PASS;
        dec_o.target     = word_i[ADDR_W-1:0];
        dec_o.len        = word_i[LEN_LSB +: LEN_W];
        dec_o.fetch      = fetch_v;
        dec_o.serial     = serial_v;
        dec_o.cond       = word_i[COND_BIT];
        dec_o.bidx       = word_i[BIDX_LSB +: BIDX_W];
        dec_o.force_take = word_i[FORCE_BIT];
        dec_o.is_end     = (op == OP_EXEC_END) || (op == OP_BEXEC_END) ||
                           (op == OP_PEXEC_END) || (op == OP_BEXEC_CL_END);
        case (op)
            OP_EXEC, OP_EXEC_END: begin
                dec_o.kind  = K_CLAUSE_ALWAYS;
                dec_o.clean = word_i[CLEAN_BIT];
            end
            OP_BEXEC, OP_BEXEC_END: begin
                dec_o.kind  = K_CLAUSE_BOOL;
                dec_o.clean = 1'b0;
            end
            OP_BEXEC_CL, OP_BEXEC_CL_END: begin
                dec_o.kind  = K_CLAUSE_BOOL;
                dec_o.clean = 1'b1;
            end
            OP_PEXEC, OP_PEXEC_END: begin
                dec_o.kind  = K_CLAUSE_PRED;
                dec_o.clean = word_i[CLEAN_BIT];
            end
            OP_LOOP_BEGIN, OP_LOOP_CLOSE: dec_o.kind = K_LOOP;
            OP_CALL:                      dec_o.kind = K_CALL;
            OP_RET:                       dec_o.kind = K_RET;
            OP_JUMP:                      dec_o.kind = K_JUMP;
            default:                      dec_o.kind = K_PASS;
        endcase
    end
endmodule

// File: rtl/cfs_pred_eval.sv
module cfs_pred_eval #(
    parameter int LANES = 64
) (
    input  logic [LANES-1:0] pred_i,
    input  logic [LANES-1:0] live_i,
    input  logic             want_i,
    output logic             hit_o
);
    logic [LANES-1:0] lane_pass;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_pass[g] = live_i[g] & (pred_i[g] == want_i);
    end

    assign hit_o = |lane_pass;
endmodule

// File: rtl/cfs_call_stack.sv
module cfs_call_stack #(
    parameter int DEPTH = 4,
    parameter int W     = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] push_data_i,
    output logic [W-1:0] top_o,
    output logic         full_o,
    output logic         empty_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     mem [DEPTH];
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] count_m1;

    assign count_m1 = count - 1'b1;
    assign full_o   = (count == CNT_W'(DEPTH));
    assign empty_o  = (count == '0);
    assign top_o    = mem[count_m1[PTR_W-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push_i && !full_o) begin
            mem[count[PTR_W-1:0]] <= push_data_i;
            count <= count + 1'b1;
        end else if (pop_i && !empty_o) begin
            count <= count_m1;
        end
    end

    assert_push_has_room_R11: assert property (@(posedge clk) disable iff (rst)
        push_i |-> !full_o);
    assert_pop_has_entry_R11: assert property (@(posedge clk) disable iff (rst)
        pop_i |-> !empty_o);
    assert_depth_bound_R10: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));
    assert_full_holds_R11: assert property (@(posedge clk) disable iff (rst)
        (full_o && !pop_i) |=> full_o);
endmodule

// File: rtl/cfs_sequencer.sv
module cfs_sequencer
    import cfs_pkg::*;
#(
    parameter int LANES       = 64,
    parameter int STACK_DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 instr_valid,
    input  logic [WORD_W-1:0]    instr_word,
    output logic                 instr_ready,
    input  logic [(1<<BIDX_W)-1:0] bool_bank,
    input  logic [LANES-1:0]     lane_pred,
    input  logic [LANES-1:0]     lane_live,
    input  logic                 pred_valid,
    output logic                 clause_valid,
    output logic [ADDR_W-1:0]    clause_addr,
    output logic [LEN_W-1:0]     clause_len,
    output logic [SLOTS-1:0]     slot_fetch,
    output logic [SLOTS-1:0]     slot_serial,
    output logic [ADDR_W-1:0]    next_pc,
    output logic                 prog_done,
    output logic                 stack_err,
    output logic                 loop_req,
    output logic [WORD_W-1:0]    loop_word,
    input  logic                 loop_ack,
    input  logic                 loop_taken,
    input  logic [ADDR_W-1:0]    loop_target
);
    cf_dec_t          dec;
    seq_state_e       state;
    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] pc_inc;
    logic [ADDR_W-1:0] stk_top;
    logic             stk_full, stk_empty, stk_push, stk_pop;
    logic             pred_stale;
    logic             bool_hit, pred_hit, run, take, accept, pred_block;

    cfs_decode u_decode (
        .word_i (instr_word),
        .dec_o  (dec)
    );

    cfs_pred_eval #(.LANES(LANES)) u_pred (
        .pred_i (lane_pred),
        .live_i (lane_live),
        .want_i (dec.cond),
        .hit_o  (pred_hit)
    );

    cfs_call_stack #(.DEPTH(STACK_DEPTH), .W(ADDR_W)) u_stack (
        .clk         (clk),
        .rst         (rst),
        .push_i      (stk_push),
        .pop_i       (stk_pop),
        .push_data_i (pc_inc),
        .top_o       (stk_top),
        .full_o      (stk_full),
        .empty_o     (stk_empty)
    );

    assign pc_inc     = pc + 1'b1;
    assign bool_hit   = (bool_bank[dec.bidx] == dec.cond);
    assign take       = dec.force_take | bool_hit;
    assign pred_block = pred_stale && !pred_valid && (dec.kind == K_CLAUSE_PRED);
    assign instr_ready = (state == S_RUN) && !pred_block;
    assign accept     = instr_valid && instr_ready;

    always_comb begin
        case (dec.kind)
            K_CLAUSE_ALWAYS: run = 1'b1;
            K_CLAUSE_BOOL:   run = bool_hit;
            K_CLAUSE_PRED:   run = pred_hit;
            default:         run = 1'b0;
        endcase
    end

    assign stk_push = accept && (dec.kind == K_CALL) && take && !stk_full;
    assign stk_pop  = accept && (dec.kind == K_RET) && !stk_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= S_RUN;
            pc           <= '0;
            clause_valid <= 1'b0;
            clause_addr  <= '0;
            clause_len   <= '0;
            slot_fetch   <= '0;
            slot_serial  <= '0;
            stack_err    <= 1'b0;
            pred_stale   <= 1'b0;
            loop_req     <= 1'b0;
            loop_word    <= '0;
        end else begin
            clause_valid <= 1'b0;
            loop_req     <= 1'b0;
            if (pred_valid) pred_stale <= 1'b0;
            case (state)
                S_RUN: if (accept) begin
                    if (is_clause(dec.kind)) begin
                        pc <= pc_inc;
                        if (run) begin
                            clause_valid <= 1'b1;
                            clause_addr  <= dec.target;
                            clause_len   <= dec.len;
                            slot_fetch   <= dec.fetch;
                            slot_serial  <= dec.serial;
                            if (!dec.clean) pred_stale <= 1'b1;
                            if (dec.is_end) state <= S_DONE;
                        end
                    end else begin
                        case (dec.kind)
                            K_JUMP: pc <= take ? dec.target : pc_inc;
                            K_CALL: begin
                                if (!take) begin
                                    pc <= pc_inc;
                                end else if (stk_full) begin
                                    stack_err <= 1'b1;
                                    pc        <= pc_inc;
                                end else begin
                                    pc <= dec.target;
                                end
                            end
                            K_RET: begin
                                if (stk_empty) begin
                                    stack_err <= 1'b1;
                                    pc        <= pc_inc;
                                end else begin
                                    pc <= stk_top;
                                end
                            end
                            K_LOOP: begin
                                loop_req  <= 1'b1;
                                loop_word <= instr_word;
                                state     <= S_LOOP;
                            end
                            default: pc <= pc_inc;
                        endcase
                    end
                end
                S_LOOP: if (loop_ack) begin
                    pc    <= loop_taken ? loop_target : pc_inc;
                    state <= S_RUN;
                end
                default: state <= S_DONE;
            endcase
        end
    end

    assign next_pc   = pc;
    assign prog_done = (state == S_DONE);

    assert_clause_follows_accept_R2: assert property (@(posedge clk) disable iff (rst)
        clause_valid |-> $past(accept));
    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        prog_done |=> (prog_done && $stable(next_pc)));
    assert_done_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        prog_done |-> !instr_ready);
    assert_loop_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        loop_req |=> !loop_req);
    assert_loop_holds_R12: assert property (@(posedge clk) disable iff (rst)
        loop_req |-> !instr_ready);
    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        stack_err |=> stack_err);
    assert_stale_stall_R8: assert property (@(posedge clk) disable iff (rst)
        (clause_valid && $past(!dec.clean) && !pred_valid && instr_valid &&
         dec.kind == K_CLAUSE_PRED) |-> !instr_ready);
endmodule

// File: tb/test_cfs_sequencer.sv
`timescale 1ns/1ps
module test_cfs_sequencer;
    logic        clk = 1'b0;
    logic        rst;
    logic        instr_valid;
    logic [47:0] instr_word;
    logic        instr_ready;
    logic [255:0] bool_bank;
    logic [63:0] lane_pred, lane_live;
    logic        pred_valid;
    logic        clause_valid;
    logic [11:0] clause_addr;
    logic [2:0]  clause_len;
    logic [5:0]  slot_fetch, slot_serial;
    logic [11:0] next_pc;
    logic        prog_done, stack_err, loop_req;
    logic [47:0] loop_word;
    logic        loop_ack, loop_taken;
    logic [11:0] loop_target;

    always #2.5 clk = ~clk;

    cfs_sequencer i_cfs_sequencer (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
        .instr_ready(instr_ready), .bool_bank(bool_bank), .lane_pred(lane_pred),
        .lane_live(lane_live), .pred_valid(pred_valid), .clause_valid(clause_valid),
        .clause_addr(clause_addr), .clause_len(clause_len), .slot_fetch(slot_fetch),
        .slot_serial(slot_serial), .next_pc(next_pc), .prog_done(prog_done),
        .stack_err(stack_err), .loop_req(loop_req), .loop_word(loop_word),
        .loop_ack(loop_ack), .loop_taken(loop_taken), .loop_target(loop_target)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    typedef struct {
        bit          cv;
        logic [11:0] addr;
        logic [2:0]  len;
        logic [5:0]  f;
        logic [5:0]  s;
        logic [11:0] pc;
        bit          done;
        bit          err;
        string       tag;
    } exp_t;
    exp_t q[$];

    logic [11:0] m_pc = '0;
    logic [11:0] m_stk[$];
    bit m_err = 0;
    bit m_done = 0;

    function automatic void chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endfunction

    function automatic logic [47:0] mk(logic [3:0] op, logic [11:0] a, logic [2:0] n,
                                       logic [11:0] seq, bit cond, bit cln,
                                       logic [7:0] bi, bit frc);
        logic [47:0] w;
        w = '0;
        w[11:0] = a; w[14:12] = n; w[27:16] = seq; w[33] = frc;
        w[42] = cond; w[47:44] = op;
        if (op inside {4'd1, 4'd2, 4'd5, 4'd6}) w[41] = cln;
        else w[41:34] = bi;
        return w;
    endfunction

    // Driver: present a word, wait for acceptance, queue the expected result.
    task automatic send(input logic [47:0] w, input string tag);
        exp_t e;
        logic [3:0] op;
        bit bhit, phit, run;
        instr_word = w; instr_valid = 1'b1; #1;
        while (!instr_ready) begin @(negedge clk); #1; end
        op   = w[47:44];
        bhit = (bool_bank[w[41:34]] == w[42]);
        phit = w[42] ? |(lane_pred & lane_live) : |(~lane_pred & lane_live);
        e.cv = 0; e.addr = w[11:0]; e.len = w[14:12]; e.tag = tag;
        for (int i = 0; i < 6; i++) begin
            e.f[i] = w[16 + 2*i];
            e.s[i] = w[17 + 2*i];
        end
        if (op inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd13, 4'd14}) begin
            if (op inside {4'd1, 4'd2}) run = 1;
            else if (op inside {4'd5, 4'd6}) run = phit;
            else run = bhit;
            e.cv = run;
            if (run && op inside {4'd2, 4'd4, 4'd6, 4'd14}) m_done = 1;
            m_pc = m_pc + 12'd1;
        end else if (op == 4'd11) begin
            m_pc = (w[33] || bhit) ? w[11:0] : m_pc + 12'd1;
        end else if (op == 4'd9) begin
            if (w[33] || bhit) begin
                if (m_stk.size() == 4) begin m_err = 1; m_pc = m_pc + 12'd1; end
                else begin m_stk.push_back(m_pc + 12'd1); m_pc = w[11:0]; end
            end else m_pc = m_pc + 12'd1;
        end else if (op == 4'd10) begin
            if (m_stk.size() == 0) begin m_err = 1; m_pc = m_pc + 12'd1; end
            else m_pc = m_stk.pop_back();
        end else begin
            m_pc = m_pc + 12'd1;
        end
        e.pc = m_pc; e.done = m_done; e.err = m_err;
        q.push_back(e);
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    // Monitor: results are registered, due at the falling edge after acceptance.
    always @(negedge clk) begin
        exp_t e;
        if (q.size() > 0) begin
            e = q.pop_front();
            chk({e.tag, " clause_valid"}, clause_valid, e.cv);
            if (e.cv) begin
                chk({e.tag, " clause_addr"}, clause_addr, e.addr);
                chk({e.tag, " clause_len"}, clause_len, e.len);
                chk({e.tag, " R3 slot_fetch"}, slot_fetch, e.f);
                chk({e.tag, " R3 slot_serial"}, slot_serial, e.s);
            end
            chk({e.tag, " next_pc"}, next_pc, e.pc);
            chk({e.tag, " prog_done"}, prog_done, e.done);
            chk({e.tag, " stack_err"}, stack_err, e.err);
        end
    end

    task automatic loop_case(input logic [47:0] w, input bit tk, input logic [11:0] tgt);
        instr_word = w; instr_valid = 1'b1; #1;
        while (!instr_ready) begin @(negedge clk); #1; end
        @(negedge clk); instr_valid = 1'b0; #1;
        chk("R12 loop_req strobe", loop_req, 1);
        chk("R12 loop_word", loop_word, w);
        chk("R12 ready held low", instr_ready, 0);
        @(negedge clk); #1;
        chk("R12 loop_req one cycle", loop_req, 0);
        chk("R12 still waiting", instr_ready, 0);
        loop_ack = 1'b1; loop_taken = tk; loop_target = tgt;
        @(negedge clk); loop_ack = 1'b0; #1;
        m_pc = tk ? tgt : m_pc + 12'd1;
        chk("R12 pc after ack", next_pc, m_pc);
        chk("R12 ready after ack", instr_ready, 1);
    endtask

    initial begin
        rst = 1'b1; instr_valid = 1'b0; instr_word = '0;
        bool_bank = '0; bool_bank[5] = 1'b1;
        lane_pred = '0; lane_live = '1; pred_valid = 1'b1;
        loop_ack = 1'b0; loop_taken = 1'b0; loop_target = '0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 next_pc in reset", next_pc, 0);
        chk("R1 clause_valid in reset", clause_valid, 0);
        rst = 1'b0;
        @(negedge clk); #1;
        chk("R1 next_pc", next_pc, 0);
        chk("R1 prog_done", prog_done, 0);
        chk("R1 stack_err", stack_err, 0);
        chk("R1 loop_req", loop_req, 0);
        chk("R1 ready", instr_ready, 1);
        @(negedge clk);

        send(mk(4'd1, 12'h123, 3'd3, 12'h9A5, 0, 1, 0, 0), "R2 exec");
        send(mk(4'd1, 12'h0F0, 3'd6, 12'h5A3, 0, 1, 0, 0), "R2 exec second");
        send(mk(4'd3, 12'h010, 3'd2, 12'hC0F, 1, 0, 8'd5, 0), "R4 bool hit");
        send(mk(4'd3, 12'h020, 3'd2, 12'h000, 1, 0, 8'd200, 0), "R4 bool miss");
        send(mk(4'd13, 12'h030, 3'd1, 12'h003, 0, 0, 8'd200, 0), "R4 bool expect false");

        lane_pred = 64'd1 << 37;
        send(mk(4'd5, 12'h040, 3'd4, 12'h0AA, 1, 1, 0, 0), "R5 one lane");
        lane_live = ~(64'd1 << 37);
        send(mk(4'd5, 12'h041, 3'd4, 12'h0AA, 1, 1, 0, 0), "R5 lane not live");
        lane_live = '1; lane_pred = '0;
        send(mk(4'd5, 12'h042, 3'd4, 12'h0AA, 1, 1, 0, 0), "R5 no lane");
        lane_pred = '1;
        send(mk(4'd5, 12'h043, 3'd2, 12'h0F0, 0, 1, 0, 0), "R6 all set");
        lane_pred = ~(64'd1 << 63);
        send(mk(4'd5, 12'h044, 3'd2, 12'h0F0, 0, 1, 0, 0), "R6 one clear");
        lane_live = '0; lane_pred = '0;
        send(mk(4'd5, 12'h045, 3'd2, 12'h0F0, 0, 1, 0, 0), "R6 no live lanes");
        lane_live = '1;

        send(mk(4'd4, 12'h050, 3'd1, 12'h0, 1, 0, 8'd200, 0), "R7 cond end not met");
        send(mk(4'd6, 12'h051, 3'd1, 12'h0, 1, 1, 0, 0), "R7 pred end not met");

        send(mk(4'd11, 12'h040, 3'd0, 12'h0, 1, 0, 8'd5, 0), "R9 jump taken");
        send(mk(4'd11, 12'h070, 3'd0, 12'h0, 0, 0, 8'd5, 0), "R9 jump not taken");
        send(mk(4'd11, 12'h080, 3'd0, 12'h0, 0, 0, 8'd5, 1), "R9 jump forced");

        send(mk(4'd10, 12'h0, 3'd0, 12'h0, 0, 0, 0, 0), "R11 return on empty");
        send(mk(4'd9, 12'h200, 3'd0, 12'h0, 1, 0, 8'd5, 0), "R10 call 1");
        send(mk(4'd9, 12'h300, 3'd0, 12'h0, 0, 0, 8'd5, 0), "R10 call not taken");
        send(mk(4'd9, 12'h210, 3'd0, 12'h0, 1, 0, 8'd5, 0), "R10 call 2");
        send(mk(4'd9, 12'h220, 3'd0, 12'h0, 0, 0, 8'd0, 1), "R10 call 3 forced");
        send(mk(4'd9, 12'h230, 3'd0, 12'h0, 1, 0, 8'd5, 0), "R10 call 4");
        send(mk(4'd9, 12'h240, 3'd0, 12'h0, 1, 0, 8'd5, 0), "R11 call overflow");
        for (int k = 0; k < 4; k++)
            send(mk(4'd10, 12'h0, 3'd0, 12'h0, 0, 0, 0, 0), "R10 return");
        send(mk(4'd10, 12'h0, 3'd0, 12'h0, 0, 0, 0, 0), "R11 return empty again");

        // Predicate stall after a dirty clause.
        pred_valid = 1'b0;
        send(mk(4'd1, 12'h100, 3'd2, 12'h0, 0, 0, 0, 0), "R8 dirty exec");
        lane_pred = 64'd1 << 4;
        instr_word = mk(4'd5, 12'h110, 3'd1, 12'h0, 1, 1, 0, 0); instr_valid = 1'b1; #1;
        chk("R8 stall on stale predicate", instr_ready, 0);
        @(negedge clk); #1;
        chk("R8 stall persists", instr_ready, 0);
        pred_valid = 1'b1; #1;
        chk("R8 released by pred_valid", instr_ready, 1);
        send(mk(4'd5, 12'h110, 3'd1, 12'h0, 1, 1, 0, 0), "R8 pred after release");
        pred_valid = 1'b0;
        send(mk(4'd13, 12'h120, 3'd1, 12'h0, 1, 0, 8'd5, 0), "R8 clean bool exec");
        instr_word = mk(4'd5, 12'h130, 3'd1, 12'h0, 1, 1, 0, 0); instr_valid = 1'b1; #1;
        chk("R8 no stall after clean clause", instr_ready, 1);
        send(mk(4'd5, 12'h130, 3'd1, 12'h0, 1, 1, 0, 0), "R8 pred after clean");
        pred_valid = 1'b1;

        loop_case(mk(4'd7, 12'h0, 3'd0, 12'h0, 0, 0, 0, 0), 1, 12'h300);
        loop_case(mk(4'd8, 12'h0, 3'd0, 12'h0, 0, 0, 0, 0), 0, 12'h3FF);
        send(mk(4'd12, 12'h0, 3'd0, 12'h0, 0, 0, 0, 0), "R12 alloc advances");
        send(mk(4'd15, 12'h0, 3'd0, 12'h0, 0, 0, 0, 0), "R12 fetch-done hint advances");

        send(mk(4'd14, 12'h140, 3'd5, 12'hFFF, 1, 0, 8'd5, 0), "R7 clean end met");
        @(negedge clk); #1;
        chk("R7 ready low after end", instr_ready, 0);
        chk("R7 pc frozen", next_pc, m_pc);
        chk("R7 done sticky", prog_done, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        finished = 1;
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule